// File: doc/BRIEF.md
# Missed Isochronous Cycle Detector

This block follows the bus activity of a serial-bus node that records isochronous streams. It tracks whether the node is inside a real isochronous period, which a cycle start packet opens, or inside a substitute period that the block opens itself when a cycle start seems to have been missed. A downstream recorder uses a one-clock request pulse from the block to synthesize a cycle mark into the recorded stream.

A substitute period opens in one of two ways. The first is an isochronous packet on a recorded channel that arrives while no period is open. The second is the local cycle offset wrapping past its last count and then reaching a late threshold, with no cycle start seen in between. An arbitration gap closes whichever period is open. A 64-bit channel mask, loaded as a whole word through a write port, selects the channels that count as recorded.

All flags are registered. Each clock, the block evaluates its conditions in parallel against the registered state and the inputs sampled at that clock edge. The result is visible just after that edge. The cycle-start, arbitration-gap and first-quadlet strobes are assumed never to occur in the same clock.

Top module: `missed_cycle_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the isochronous flag, the substitute flag, the rollover flag and the mark pulse are all 0 after that edge.
- R2: A cycle-start strobe makes the isochronous flag 1 and both the substitute flag and the rollover flag 0 after the edge.
- R3: An arbitration-gap strobe while either period flag is 1 clears both period flags. The rollover flag is cleared as well only if the isochronous flag was the one set. A gap while neither flag is set changes nothing.
- R4: With both period flags 0, a first-quadlet strobe starts a substitute period when all of the following hold: data bits [7:4] equal 4'hA, and the mask bit indexed by the channel number in data bits [13:8] is 1.
- R5: When the cycle offset equals 3071, the rollover flag is 1 after the edge, unless a cycle start occurs in the same clock. This also holds when an arbitration gap closes a real period in that clock.
- R6: With the rollover flag 1, both period flags 0 and the cycle offset equal to 3050, the substitute flag is 1 after the edge.
- R7: The mark pulse is 1 for exactly the first clock in which the substitute flag is 1 after being 0. It is never raised when only the isochronous flag rises.
- R8: A cycle start that coincides with offset 3050 or 3071 takes precedence. The result is the isochronous flag set, the substitute flag and rollover flag clear, and no mark pulse.
- R9: A mask write replaces all 64 bits, and bit n set means channel n is recorded. A packet that arrives in the same clock as the write is judged against the old mask.
- R10: A matching packet that arrives while either period flag is 1 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start_i | input | 1 | Cycle start packet sent or received |
| arb_gap_i | input | 1 | Arbitration (subaction) gap detected |
| first_q_i | input | 1 | First quadlet of a valid received packet |
| rx_word_i | input | 32 | Received quadlet, bit 31 MSB |
| offset_i | input | 12 | Local cycle offset, 0 to 3071 |
| mask_we_i | input | 1 | Load the channel mask |
| mask_wdata_i | input | 64 | New channel mask |
| iso_active_o | output | 1 | Real isochronous period open |
| sub_active_o | output | 1 | Substitute isochronous period open |
| wrap_seen_o | output | 1 | Offset rolled over with no cycle start since |
| mark_req_o | output | 1 | One-clock request for a synthesized cycle mark |

## Verification
The critical same-cycle collision is a cycle start arriving in the very clock that would otherwise open a substitute period. One form is the late threshold: offset 3050 with the rollover flag set. The other is a cycle start at offset 3071, where the rollover set competes with the clear. The bench walks the offset through a full wrap, then drives the cycle-start strobe exactly at those offsets. A behavioural model, which gives cycle start priority, judges the flags and the absence of a mark pulse on every clock. A mask write in the same clock as a matching packet is provoked the same way, to show which mask is used.

// File: rtl/mcd_pkg.sv
// Shared constants and types for the missed isochronous cycle detector.
package mcd_pkg;

    // Transaction code carried by isochronous data packets
    localparam logic [3:0] TCODE_ISO = 4'hA;
    // Bit positions of the fields decoded in the first quadlet
    localparam int TCODE_LSB = 4;
    localparam int CHAN_LSB  = 8;

    // Registered period state
    typedef struct packed {
        logic iso;
        logic sub;
        logic wrap;
    } period_t;

endpackage

// File: rtl/chan_mask_reg.sv
// Channel selection register.
// Holds one bit per channel; a write replaces the whole word.
// Assumes the writer never needs partial updates.
module chan_mask_reg #(
    parameter int NUM_CHAN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [NUM_CHAN-1:0] wdata_i,
    output logic [NUM_CHAN-1:0] mask_o
);

    // Load the mask on write; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (we_i)
            mask_o <= wdata_i;
    end

endmodule

// File: rtl/iso_pkt_classifier.sv
// Isochronous packet classifier.
// Flags a first quadlet whose transaction code is isochronous and whose
// channel is enabled in the mask. Purely combinational; assumes the
// quadlet is only meaningful while first_q_i is high.
module iso_pkt_classifier
    import mcd_pkg::*;
#(
    parameter int CHAN_W   = 6,
    parameter int NUM_CHAN = 1 << CHAN_W
) (
    input  logic                first_q_i,
    input  logic [3:0]          tcode_i,
    input  logic [CHAN_W-1:0]   chan_i,
    input  logic [NUM_CHAN-1:0] mask_i,
    output logic                hit_o
);

    logic [NUM_CHAN-1:0] chan_hit;

    // One comparator per channel, qualified by that channel's mask bit
    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        assign chan_hit[g] = mask_i[g] && (chan_i == CHAN_W'(g));
    end

    // Combine strobe, code match and channel match
    always_comb begin
        hit_o = first_q_i && (tcode_i == TCODE_ISO) && (|chan_hit);
    end

endmodule

// File: rtl/period_tracker.sv
// Period tracker.
// Holds the real-period, substitute-period and rollover flags and raises
// a one-clock mark request when a substitute period opens. Assumes the
// cycle-start, gap and packet strobes are mutually exclusive; cycle start
// is given priority over every other condition regardless.
module period_tracker
    import mcd_pkg::*;
#(
    parameter int OFFSET_W    = 12,
    parameter int OFFSET_LAST = 3071,
    parameter int LATE_OFFSET = 3050
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_start_i,
    input  logic                arb_gap_i,
    input  logic                pkt_hit_i,
    input  logic [OFFSET_W-1:0] offset_i,
    output period_t             state_o,
    output logic                mark_o
);

    localparam logic [OFFSET_W-1:0] LAST_CNT = OFFSET_W'(OFFSET_LAST);
    localparam logic [OFFSET_W-1:0] LATE_CNT = OFFSET_W'(LATE_OFFSET);

    period_t cur, nxt;
    logic    at_last, at_late, idle, mark_q;

    // Offset decodes and idle condition
    always_comb begin
        at_last = (offset_i == LAST_CNT);
        at_late = (offset_i == LATE_CNT);
        idle    = !cur.iso && !cur.sub;
    end

    // Next-state evaluation: all conditions in parallel, cycle start last wins
    always_comb begin
        nxt = cur;
        if (arb_gap_i && !idle) begin
            nxt.iso = 1'b0;
            nxt.sub = 1'b0;
            if (cur.iso)
                nxt.wrap = 1'b0;
        end
        if (idle && pkt_hit_i)
            nxt.sub = 1'b1;
        if (at_last)
            nxt.wrap = 1'b1;
        if (idle && cur.wrap && at_late)
            nxt.sub = 1'b1;
        if (cyc_start_i) begin
            nxt.iso  = 1'b1;
            nxt.sub  = 1'b0;
            nxt.wrap = 1'b0;
        end
    end

    // State and mark-pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            mark_q <= 1'b0;
        end else begin
            cur    <= nxt;
            mark_q <= nxt.sub && !cur.sub;
        end
    end

    assign state_o = cur;
    assign mark_o  = mark_q;

    // R1: reset clears all flags
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!cur.iso && !cur.sub && !cur.wrap && !mark_q));

    // R2: cycle start opens a real period
    a_r2_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_i |=> (cur.iso && !cur.sub && !cur.wrap));

    // R3: gap closes an open period
    a_r3_gap_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_gap_i && (cur.iso || cur.sub) && !cyc_start_i) |=> (!cur.iso && !cur.sub));

    // R5: offset at last count records a rollover
    a_r5_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && !cyc_start_i) |=> cur.wrap);

    // R6: late threshold after rollover opens a substitute period
    a_r6_late_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.wrap && idle && at_late && !cyc_start_i) |=> cur.sub);

    // R7: mark is a single-clock pulse and only with a substitute period
    a_r7_mark_single: assert property (@(posedge clk) disable iff (!rst_n)
        mark_q |=> !mark_q);
    a_r7_mark_with_sub: assert property (@(posedge clk) disable iff (!rst_n)
        mark_q |-> cur.sub);

    // Real and substitute periods never overlap
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur.iso && cur.sub));

endmodule

// File: rtl/missed_cycle_detector.sv
// Missed isochronous cycle detector (top).
// Ties the channel mask, the packet classifier and the period tracker
// together. Assumes the strobe inputs are mutually exclusive and the
// offset counts 0..OFFSET_LAST.
module missed_cycle_detector
    import mcd_pkg::*;
#(
    parameter int CHAN_W      = 6,
    parameter int OFFSET_W    = 12,
    parameter int OFFSET_LAST = 3071,
    parameter int LATE_OFFSET = 3050
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cyc_start_i,
    input  logic                       arb_gap_i,
    input  logic                       first_q_i,
    input  logic [31:0]                rx_word_i,
    input  logic [OFFSET_W-1:0]        offset_i,
    input  logic                       mask_we_i,
    input  logic [(1 << CHAN_W)-1:0]   mask_wdata_i,
    output logic                       iso_active_o,
    output logic                       sub_active_o,
    output logic                       wrap_seen_o,
    output logic                       mark_req_o
);

    localparam int NUM_CHAN = 1 << CHAN_W;

    logic [NUM_CHAN-1:0] mask;
    logic                pkt_hit;
    period_t             state;
    logic                word_unused;

    // Fields not used by the classifier
    assign word_unused = ^{rx_word_i[31:CHAN_LSB+CHAN_W], rx_word_i[TCODE_LSB-1:0]};

    chan_mask_reg #(.NUM_CHAN(NUM_CHAN)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask)
    );

    iso_pkt_classifier #(.CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN)) u_cls (
        .first_q_i (first_q_i),
        .tcode_i   (rx_word_i[TCODE_LSB+3:TCODE_LSB]),
        .chan_i    (rx_word_i[CHAN_LSB+CHAN_W-1:CHAN_LSB]),
        .mask_i    (mask),
        .hit_o     (pkt_hit)
    );

    period_tracker #(
        .OFFSET_W    (OFFSET_W),
        .OFFSET_LAST (OFFSET_LAST),
        .LATE_OFFSET (LATE_OFFSET)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start_i (cyc_start_i),
        .arb_gap_i   (arb_gap_i),
        .pkt_hit_i   (pkt_hit),
        .offset_i    (offset_i),
        .state_o     (state),
        .mark_o      (mark_req_o)
    );

    // Output mapping
    assign iso_active_o = state.iso;
    assign sub_active_o = state.sub;
    assign wrap_seen_o  = state.wrap;

    // R4/R10: a recorded-channel packet opens a substitute period only when idle
    a_r4_pkt_opens_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_hit && !state.iso && !state.sub && !cyc_start_i) |=> (sub_active_o && mark_req_o));
    a_r10_pkt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_hit && state.iso) |=> (iso_active_o && !mark_req_o));

    // R8: cycle start never produces a mark
    a_r8_cs_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_i |=> !mark_req_o);

endmodule

// File: tb/missed_cycle_detector_tb.sv
module missed_cycle_detector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start_i = 1'b0, arb_gap_i = 1'b0, first_q_i = 1'b0;
    logic [31:0] rx_word_i = '0;
    logic [11:0] offset_i = '0;
    logic        mask_we_i = 1'b0;
    logic [63:0] mask_wdata_i = '0;
    logic        iso_active_o, sub_active_o, wrap_seen_o, mark_req_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    bit m_iso, m_sub, m_wrap, m_mark;
    bit [63:0] m_mask;
    int off = 0;

    always #2.5 clk = ~clk;

    missed_cycle_detector u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i), .arb_gap_i(arb_gap_i),
        .first_q_i(first_q_i), .rx_word_i(rx_word_i), .offset_i(offset_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .iso_active_o(iso_active_o), .sub_active_o(sub_active_o),
        .wrap_seen_o(wrap_seen_o), .mark_req_o(mark_req_o)
    );

    function automatic bit [31:0] pkt(input int tcode, input int chan);
        return (32'(chan) << 8) | (32'(tcode) << 4) | 32'h0055_0003;
    endfunction

    task automatic model_update();
        bit ni, ns, nr, nm;
        if (!rst_n) begin
            ni = 0; ns = 0; nr = 0; nm = 0;
            m_mask = '0;
        end else if (cyc_start_i) begin
            ni = 1; ns = 0; nr = 0; nm = 0;
        end else begin
            ni = m_iso; ns = m_sub; nr = m_wrap;
            if (arb_gap_i && (m_iso || m_sub)) begin
                ni = 0; ns = 0;
                if (m_iso) nr = 0;
            end
            if (first_q_i && !m_iso && !m_sub && rx_word_i[7:4] == 4'hA
                && m_mask[rx_word_i[13:8]]) ns = 1;
            if (offset_i == 12'd3071) nr = 1;
            if (m_wrap && !m_iso && !m_sub && offset_i == 12'd3050) ns = 1;
            nm = ns && !m_sub;
        end
        if (rst_n && mask_we_i) m_mask = mask_wdata_i;
        m_iso = ni; m_sub = ns; m_wrap = nr; m_mark = nm;
    endtask

    // One clock: apply inputs already driven, advance model, compare outputs
    task automatic step(input string req);
        offset_i = 12'(off);
        @(posedge clk);
        #1;
        model_update();
        tests++;
        if ({iso_active_o, sub_active_o, wrap_seen_o, mark_req_o} !==
            {m_iso, m_sub, m_wrap, m_mark}) begin
            fails++;
            $display("FAIL %s off=%0d actual iso/sub/wrap/mark=%b expected=%b", req, off,
                {iso_active_o, sub_active_o, wrap_seen_o, mark_req_o},
                {m_iso, m_sub, m_wrap, m_mark});
        end
        cyc_start_i = 0; arb_gap_i = 0; first_q_i = 0; mask_we_i = 0;
        off = (off == 3071) ? 0 : off + 1;
    endtask

    task automatic run_to(input int target, input string req);
        while (off != target) step(req);
    endtask

    task automatic send_pkt(input int tcode, input int chan, input string req);
        first_q_i = 1; rx_word_i = pkt(tcode, chan);
        step(req);
    endtask

    initial begin
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");
        // mask: channels 0, 5, 63
        mask_we_i = 1; mask_wdata_i = 64'h8000_0000_0000_0021;
        step("R9");
        // R2: cycle start
        cyc_start_i = 1; step("R2");
        send_pkt(10, 5, "R10");            // inside real period: ignored
        arb_gap_i = 1; step("R3");         // close real period
        arb_gap_i = 1; step("R3");         // gap while idle: no effect
        send_pkt(9, 5, "R4");              // wrong code
        send_pkt(10, 6, "R4");             // channel not recorded
        send_pkt(10, 63, "R4");            // top channel: opens substitute, mark
        step("R7");
        send_pkt(10, 0, "R10");            // already in substitute
        arb_gap_i = 1; step("R3");
        send_pkt(10, 0, "R4");             // channel 0
        cyc_start_i = 1; step("R7");       // iso rise, no mark
        arb_gap_i = 1; step("R3");
        // R9: write and packet in the same clock use the old mask
        mask_we_i = 1; mask_wdata_i = 64'h0000_0000_0000_0040;
        first_q_i = 1; rx_word_i = pkt(10, 6); step("R9");
        send_pkt(10, 5, "R9");             // channel 5 no longer recorded
        send_pkt(10, 6, "R9");
        arb_gap_i = 1; step("R3");
        // R5/R6: rollover then late threshold opens substitute
        run_to(3071, "R5"); step("R5");
        run_to(3050, "R6"); step("R6"); step("R7");
        // gap closing substitute keeps rollover
        arb_gap_i = 1; step("R3");
        run_to(3050, "R6"); step("R6");
        arb_gap_i = 1; step("R3");
        // R8: cycle start coinciding with late threshold
        run_to(3050, "R8"); cyc_start_i = 1; step("R8");
        // rollover while in real period, then gap at offset 3071
        run_to(3071, "R11"); arb_gap_i = 1; step("R5");
        run_to(3050, "R6"); step("R6");
        // R8: cycle start at offset 3071
        arb_gap_i = 1; step("R3");
        run_to(3071, "R8"); cyc_start_i = 1; step("R8");
        run_to(3060, "R8");
        // reset mid-run
        rst_n = 0; step("R1");
        rst_n = 1; step("R1");
        send_pkt(10, 6, "R1");             // mask cleared by reset
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule